// File: doc/BRIEF.md
# Peripheral DMA Channel Pair

This block moves words between one serial peripheral and system memory. The processor takes no part once a channel is set up. There are two channels. The receive channel writes each word that the peripheral has received into memory. The transmit channel reads a word from memory each time the peripheral asks for one. Each channel holds a 32-bit address pointer and a 16-bit word count. Software writes both through a small configuration port that sits in the peripheral's own register space.

Each word moved advances the channel's pointer by one word and lowers its count by one. When the count reaches zero the channel stops and raises a sticky end-of-transfer flag. The owning peripheral feeds that flag into its own status and interrupt logic. Memory is reached through a single request/grant master port, and only one access is in flight at a time. When both channels are waiting, the receive channel goes first, because a received word has nowhere else to be kept.

Top module: `pdma_pair`

## Requirements
- R1: After reset, both pointers, both counts, both end-of-transfer flags, `mem_req` and `tx_valid` are 0.
- R2: A write with `cfg_we` high updates one register, and the new value shows on the matching output at the next sampling point. `cfg_sel[1]` picks the channel (0 = receive, 1 = transmit). `cfg_sel[0]` picks the field (0 = pointer, taking all 32 bits; 1 = count, taking bits 15:0).
- R3: Writing a nonzero count clears that channel's end-of-transfer flag.
- R4: While a channel's count is 0, its peripheral request is ignored: no memory access starts, and the pointer and count stay unchanged.
- R5: A receive request with a nonzero count writes the `rx_word` presented with that request to memory at the receive pointer (`mem_we` = 1). On the grant, the pointer rises by 4 and the count falls by 1.
- R6: A transmit request with a nonzero count reads memory at the transmit pointer (`mem_we` = 0). `mem_rdata` at the grant appears on `tx_word`, with `tx_valid` high for exactly the one cycle after the grant. The pointer rises by 4 and the count falls by 1.
- R7: The grant that takes a count from 1 to 0 sets that channel's end-of-transfer flag. The flag stays set until R3 clears it.
- R8: When both channels have a pending word as the port goes free, the receive access is issued first.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: A channel holds at most one pending word. A receive request that arrives while one is pending is dropped and does not overwrite the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: bit 1 channel, bit 0 field |
| cfg_wdata | input | 32 | Configuration write data |
| rx_ptr | output | 32 | Receive address pointer |
| rx_cnt | output | 16 | Receive words remaining |
| tx_ptr | output | 32 | Transmit address pointer |
| tx_cnt | output | 16 | Transmit words remaining |
| rx_eot | output | 1 | Receive end-of-transfer flag |
| tx_eot | output | 1 | Transmit end-of-transfer flag |
| rx_req | input | 1 | Peripheral has a received word (one-cycle pulse) |
| rx_word | input | 32 | Received word, valid with rx_req |
| tx_req | input | 1 | Peripheral wants a word to send (one-cycle pulse) |
| tx_word | output | 32 | Word fetched for the peripheral |
| tx_valid | output | 1 | tx_word is new this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access completes at this clock edge |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |

## Verification
A wrong pointer shows up at the memory port on the very next access from that channel. It appears as a misplaced write in memory, or as a transmit word fetched from the wrong slot. A wrong count or a lost pending flag shows up within one grant. The count either fails to step, or the access never comes and the wait times out. A wrong end-of-transfer flag is visible at the sample right after the last grant. Broken arbitration or a port that lets its address drift during a stall is caught at the first contested or stalled cycle. The bench holds the grant low at random to create those stalls.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic {
    CH_RX = 1'b0,
    CH_TX = 1'b1
  } pdma_ch_e;

  typedef enum logic {
    FLD_PTR = 1'b0,
    FLD_CNT = 1'b1
  } pdma_fld_e;
endpackage

// File: rtl/pdma_chan.sv
module pdma_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4,
  parameter bit IS_RX  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ptr_we,
  input  logic              cfg_cnt_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_wdata,
  input  logic              word_done,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              pend,
  output logic [DATA_W-1:0] hold_data,
  output logic              eot
);
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(STEP);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cfg_cnt_val;
  logic             accept;
  logic             last_word;

  assign cfg_cnt_val = cfg_wdata[CNT_W-1:0];
  assign accept      = per_req && (cnt != '0) && !pend;
  assign last_word   = word_done && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      eot  <= 1'b0;
    end else begin
      if (cfg_ptr_we)     ptr <= cfg_wdata;
      else if (word_done) ptr <= ptr_next(ptr);

      if (cfg_cnt_we)     cnt <= cfg_cnt_val;
      else if (word_done) cnt <= cnt_next(cnt);

      if (word_done)   pend <= 1'b0;
      else if (accept) pend <= 1'b1;

      if (cfg_cnt_we && (cfg_cnt_val != '0)) eot <= 1'b0;
      else if (last_word)                    eot <= 1'b1;
    end
  end

  generate
    if (IS_RX) begin : g_hold
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (accept) hold_q <= per_wdata;
      end
      assign hold_data = hold_q;

      AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !word_done) |=> $stable(hold_q)); // R10
    end else begin : g_nohold
      assign hold_data = '0;
    end
  endgenerate

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && !pend && cnt == '0 && !cfg_cnt_we) |=> (!pend && cnt == '0)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cfg_cnt_we) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cfg_ptr_we) |=> (ptr == $past(ptr) + ADDR_W'(STEP))); // R5
  AST_EOT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cnt == CNT_W'(1) && !cfg_cnt_we) |=> eot); // R7
  AST_EOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cnt_we && cfg_cnt_val != '0) |=> !eot); // R3
  AST_DONE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> pend); // R10
endmodule

// File: rtl/pdma_mport.sv
module pdma_mport
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pend,
  input  logic              tx_pend,
  input  logic [ADDR_W-1:0] rx_ptr,
  input  logic [ADDR_W-1:0] tx_ptr,
  input  logic [DATA_W-1:0] rx_hold,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rx_word_done,
  output logic              tx_word_done,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_valid
);
  pdma_ch_e owner;
  logic     busy;
  logic     launch;
  logic     finish;
  pdma_ch_e pick;

  assign launch = !busy && (rx_pend || tx_pend);
  assign pick   = rx_pend ? CH_RX : CH_TX;
  assign finish = busy && mem_gnt;

  assign rx_word_done = finish && (owner == CH_RX);
  assign tx_word_done = finish && (owner == CH_TX);
  assign mem_req      = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      owner     <= CH_RX;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_word   <= '0;
      tx_valid  <= 1'b0;
    end else begin
      tx_valid <= tx_word_done;
      if (tx_word_done) tx_word <= mem_rdata;
      if (launch) begin
        busy      <= 1'b1;
        owner     <= pick;
        mem_we    <= (pick == CH_RX);
        mem_addr  <= (pick == CH_RX) ? rx_ptr : tx_ptr;
        mem_wdata <= (pick == CH_RX) ? rx_hold : '0;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata))); // R9
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && rx_pend && tx_pend) |=> (mem_req && mem_we)); // R8
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_done |=> (tx_valid && tx_word == $past(mem_rdata))); // R6
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_word_done, tx_word_done})); // R8
endmodule

// File: rtl/pdma_pair.sv
module pdma_pair
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] rx_ptr,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic [ADDR_W-1:0] tx_ptr,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic              rx_eot,
  output logic              tx_eot,
  input  logic              rx_req,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              tx_req,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              rx_pend, tx_pend;
  logic              rx_done_w, tx_done_w;
  logic [DATA_W-1:0] rx_hold, tx_hold_nc;
  logic [1:0]        ptr_we, cnt_we;

  for (genvar c = 0; c < 2; c++) begin : g_dec
    assign ptr_we[c] = cfg_we && (cfg_sel[1] == c[0]) && (cfg_sel[0] == FLD_PTR);
    assign cnt_we[c] = cfg_we && (cfg_sel[1] == c[0]) && (cfg_sel[0] == FLD_CNT);
  end

  pdma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP(STEP), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_ptr_we(ptr_we[CH_RX]), .cfg_cnt_we(cnt_we[CH_RX]),
    .cfg_wdata(cfg_wdata), .per_req(rx_req), .per_wdata(rx_word), .word_done(rx_done_w),
    .ptr(rx_ptr), .cnt(rx_cnt), .pend(rx_pend), .hold_data(rx_hold), .eot(rx_eot));

  pdma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP(STEP), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_ptr_we(ptr_we[CH_TX]), .cfg_cnt_we(cnt_we[CH_TX]),
    .cfg_wdata(cfg_wdata), .per_req(tx_req), .per_wdata('0), .word_done(tx_done_w),
    .ptr(tx_ptr), .cnt(tx_cnt), .pend(tx_pend), .hold_data(tx_hold_nc), .eot(tx_eot));

  pdma_mport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .rx_pend(rx_pend), .tx_pend(tx_pend),
    .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .rx_hold(rx_hold),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .rx_word_done(rx_done_w), .tx_word_done(tx_done_w),
    .tx_word(tx_word), .tx_valid(tx_valid));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !tx_valid && !rx_eot && !tx_eot)); // R1
  AST_CFG_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we[CH_RX] |=> (rx_ptr == $past(cfg_wdata))); // R2
endmodule

// File: tb/pdma_pair_bench.sv
module pdma_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rx_ptr, tx_ptr, tx_word, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] rx_cnt, tx_cnt;
  logic        rx_eot, tx_eot, tx_valid, mem_req, mem_we;
  logic        rx_req = 1'b0, tx_req = 1'b0, mem_gnt = 1'b0;
  logic [31:0] rx_word = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit gnt_en = 1'b1;
  logic [31:0] bmem [0:255];

  always #4 clk = ~clk;

  pdma_pair u_pdma_pair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_ptr(rx_ptr), .rx_cnt(rx_cnt), .tx_ptr(tx_ptr), .tx_cnt(tx_cnt),
    .rx_eot(rx_eot), .tx_eot(tx_eot), .rx_req(rx_req), .rx_word(rx_word),
    .tx_req(tx_req), .tx_word(tx_word), .tx_valid(tx_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

  function automatic logic [31:0] exp_ptr(input logic [31:0] p, input int k);
    return p + 32'(4 * k);
  endfunction

  function automatic logic [15:0] exp_cnt(input logic [15:0] c, input int k);
    return c - 16'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory model
  assign mem_rdata = bmem[mem_addr[9:2]];
  always @(posedge clk) if (mem_req && mem_gnt && mem_we) bmem[mem_addr[9:2]] <= mem_wdata;

  // grant driver and port-hold check
  logic        stall_prev = 1'b0;
  logic [31:0] s_addr, s_wdata;
  logic        s_we;
  always @(negedge clk) begin
    if (stall_prev)
      chk(mem_req && mem_addr == s_addr && mem_wdata == s_wdata && mem_we == s_we,
          "R9", mem_addr, s_addr);
    mem_gnt = rst_n && gnt_en && mem_req && ($urandom % 4 != 0);
    stall_prev = mem_req && !mem_gnt;
    s_addr = mem_addr; s_wdata = mem_wdata; s_we = mem_we;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", 32'(cyc), 32'd150000);
        finish_run();
      end
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_rx(input logic [31:0] d);
    logic [31:0] p0 = rx_ptr;
    logic [15:0] c0 = rx_cnt;
    bit moved = 1'b0;
    rx_req = 1'b1; rx_word = d;
    @(negedge clk);
    rx_req = 1'b0;
    for (int i = 0; i < 64 && !moved; i++) begin
      if (rx_cnt != c0) moved = 1'b1; else @(negedge clk);
    end
    chk(moved && rx_cnt == exp_cnt(c0, 1), "R5 cnt", 32'(rx_cnt), 32'(exp_cnt(c0, 1)));
    chk(rx_ptr == exp_ptr(p0, 1), "R5 ptr", rx_ptr, exp_ptr(p0, 1));
    chk(bmem[p0[9:2]] == d, "R5 mem", bmem[p0[9:2]], d);
  endtask

  task automatic do_tx();
    logic [31:0] p0 = tx_ptr;
    logic [15:0] c0 = tx_cnt;
    logic [31:0] e = bmem[tx_ptr[9:2]];
    bit moved = 1'b0;
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    for (int i = 0; i < 64 && !moved; i++) begin
      if (tx_cnt != c0) moved = 1'b1; else @(negedge clk);
    end
    chk(moved && tx_cnt == exp_cnt(c0, 1), "R6 cnt", 32'(tx_cnt), 32'(exp_cnt(c0, 1)));
    chk(tx_ptr == exp_ptr(p0, 1), "R6 ptr", tx_ptr, exp_ptr(p0, 1));
    chk(tx_valid && tx_word == e, "R6 word", tx_word, e);
    @(negedge clk);
    chk(!tx_valid, "R6 pulse", 32'(tx_valid), 32'd0);
  endtask

  task automatic idle_req(input bit is_tx);
    logic [31:0] p0 = is_tx ? tx_ptr : rx_ptr;
    bit seen = 1'b0;
    if (is_tx) tx_req = 1'b1; else rx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0; rx_req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      seen |= mem_req;
      @(negedge clk);
    end
    chk(!seen, "R4 no access", 32'(seen), 32'd0);
    chk((is_tx ? tx_ptr : rx_ptr) == p0, "R4 ptr", is_tx ? tx_ptr : rx_ptr, p0);
    chk((is_tx ? tx_cnt : rx_cnt) == 16'd0, "R4 cnt", 32'(is_tx ? tx_cnt : rx_cnt), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = $urandom;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_ptr == 0 && tx_ptr == 0, "R1 ptrs", rx_ptr | tx_ptr, 32'd0);
    chk(rx_cnt == 0 && tx_cnt == 0, "R1 cnts", 32'(rx_cnt | tx_cnt), 32'd0);
    chk(!rx_eot && !tx_eot && !mem_req && !tx_valid, "R1 flags",
        {28'd0, rx_eot, tx_eot, mem_req, tx_valid}, 32'd0);

    // R2 register writes
    cfg(2'b00, 32'h0000_0040);
    chk(rx_ptr == 32'h40, "R2 rx ptr", rx_ptr, 32'h40);
    cfg(2'b01, 32'hABCD_0003);
    chk(rx_cnt == 16'd3, "R2 rx cnt", 32'(rx_cnt), 32'd3);
    cfg(2'b10, 32'h0000_0100);
    chk(tx_ptr == 32'h100, "R2 tx ptr", tx_ptr, 32'h100);

    // R5 receive run, R7 end flag, R4 idle ignore
    for (int k = 0; k < 3; k++) do_rx($urandom);
    chk(rx_eot, "R7 rx eot", 32'(rx_eot), 32'd1);
    idle_req(1'b0);
    chk(rx_eot, "R7 rx eot sticky", 32'(rx_eot), 32'd1);
    cfg(2'b01, 32'd2);
    chk(!rx_eot, "R3 rx eot clear", 32'(rx_eot), 32'd0);
    for (int k = 0; k < 2; k++) do_rx($urandom);

    // R6 transmit run
    idle_req(1'b1);
    cfg(2'b11, 32'd4);
    for (int k = 0; k < 4; k++) do_tx();
    chk(tx_eot, "R7 tx eot", 32'(tx_eot), 32'd1);

    // R8 priority
    cfg(2'b00, 32'h200); cfg(2'b01, 32'd1);
    cfg(2'b10, 32'h300); cfg(2'b11, 32'd1);
    chk(!tx_eot, "R3 tx eot clear", 32'(tx_eot), 32'd0);
    rx_req = 1'b1; tx_req = 1'b1; rx_word = 32'hCAFE_0001;
    @(negedge clk);
    rx_req = 1'b0; tx_req = 1'b0;
    for (int i = 0; i < 8 && !mem_req; i++) @(negedge clk);
    chk(mem_req && mem_we && mem_addr == 32'h200, "R8 rx first", mem_addr, 32'h200);
    for (int i = 0; i < 64 && (rx_cnt != 0 || tx_cnt != 0); i++) @(negedge clk);
    chk(rx_eot && tx_eot, "R8 both finish", {30'd0, rx_eot, tx_eot}, 32'd3);

    // R10 second request while one is pending is dropped
    gnt_en = 1'b0;
    cfg(2'b00, 32'h80); cfg(2'b01, 32'd2);
    rx_req = 1'b1; rx_word = 32'h1111_AAAA;
    @(negedge clk);
    rx_word = 32'h2222_BBBB;
    @(negedge clk);
    rx_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_req && mem_wdata == 32'h1111_AAAA, "R10 held word", mem_wdata, 32'h1111_AAAA);
    gnt_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(rx_cnt == 16'd1, "R10 one transfer", 32'(rx_cnt), 32'd1);
    chk(bmem[32] == 32'h1111_AAAA, "R10 mem", bmem[32], 32'h1111_AAAA);
    chk(!mem_req, "R10 no second", 32'(mem_req), 32'd0);
    cfg(2'b01, 32'd0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      bit is_tx = $urandom % 2;
      logic [31:0] p = {22'd0, 8'($urandom), 2'b00};
      int n = 1 + $urandom % 4;
      cfg({is_tx, 1'b0}, p);
      cfg({is_tx, 1'b1}, 32'(n));
      chk(!(is_tx ? tx_eot : rx_eot), "R3 rand", 32'(is_tx ? tx_eot : rx_eot), 32'd0);
      for (int k = 0; k < n; k++) begin
        if (is_tx) do_tx(); else do_rx($urandom);
      end
      chk((is_tx ? tx_ptr : rx_ptr) == exp_ptr(p, n), "R5/R6 rand ptr",
          is_tx ? tx_ptr : rx_ptr, exp_ptr(p, n));
      chk(is_tx ? tx_eot : rx_eot, "R7 rand", 32'(is_tx ? tx_eot : rx_eot), 32'd1);
      if (it % 8 == 0) idle_req(is_tx);
    end
    finish_run();
  end
endmodule